// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two W-bit integers over several clock cycles and returns the 2W-bit product as a high word and a low word. A one-bit mode input picks how the operands are read. Unsigned mode takes them as plain binary. Signed mode takes them as two's complement: each negative operand is replaced by its magnitude, and a sign flag flips once for each negative operand. The core then multiplies the magnitudes. If the flag is set, the 2W-bit result is negated in a separate final cycle.

The multiplicand is kept as a 2W-bit value split into a low and a high half. It shifts left one bit per step, and the top bit of the low half moves into the high half. On each step where the current multiplier bit is one, the multiplicand is added into a 2W-bit accumulator, and the carry out of the low-half add feeds the high half. The multiplier shifts right one bit per step. The operation stops after the step whose remaining upper multiplier bits are all zero, so small multipliers finish early. A zero operand skips the iteration and returns zero at once.

Handshake: a start pulse is accepted only while `busy_o` is low, and it captures both operands and the mode. A start seen while busy is dropped. The caller must wait for `done_o`, a single-cycle pulse, before issuing the next request. The product outputs keep their value until the next completion.

Top module: `shiftadd_mul`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and both product words are zero.
- R2: With `is_signed_i` = 0, {`prod_hi_o`,`prod_lo_o`} equals the unsigned product of the two operands.
- R3: With `is_signed_i` = 1, {`prod_hi_o`,`prod_lo_o`} equals the two's-complement product. This includes the most negative operand, whose magnitude is 2^(W-1).
- R4: If either operand is zero, `done_o` is high in the cycle right after the accepted start, both words are zero, and `busy_o` never rises.
- R5: For a non-zero, non-negative product, `busy_o` rises after the start edge, and `done_o` pulses k+1 cycles after the start edge, where k is one plus the index of the highest set bit of the multiplier magnitude. `busy_o` falls in the same cycle `done_o` rises.
- R6: A non-zero negative product takes exactly one cycle more than R5.
- R7: A start asserted while `busy_o` is high is ignored. The operation in flight completes with its own operands, and no second result follows.
- R8: `done_o` is high for exactly one cycle per accepted operation, and the product words change only in a cycle where `done_o` is high.
- R9: No operation uses more than W add-and-shift steps. A multiplier magnitude with its top bit set takes W+1 cycles to `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, honoured only while idle |
| opa_i | input | W | Multiplicand operand |
| opb_i | input | W | Multiplier operand |
| is_signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| prod_hi_o | output | W | Upper half of the product |
| prod_lo_o | output | W | Lower half of the product |

## Verification
Each result has a fixed due time, counted in clock edges from the edge that samples the start. For a zero operand the result is due 1 edge later. For a non-negative product it is due k+1 edges later, where k is the bit length of the multiplier magnitude, and a negative product needs one edge more. The bench drives and samples on falling edges and counts edges until `done_o`, and it compares that count with the value it computed independently, so a result that arrives early or late fails even when its value is right. A 4-bit instance is swept over all operand pairs in both modes. A 32-bit instance runs directed corner operands, random operands, a start dropped while busy, and checks that the result holds after completion.

// File: rtl/shiftadd_mul_pkg.sv
package shiftadd_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_FIX  = 2'd2
  } mul_state_e;
endpackage

// File: rtl/mul_magnitude.sv
// Strips the sign of one operand; the most negative value maps to 2^(W-1).
module mul_magnitude #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         is_signed_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o
);
  always_comb begin
    neg_o = is_signed_i & val_i[W-1];
    mag_o = neg_o ? (~val_i + W'(1)) : val_i;
  end
endmodule

// File: rtl/mul_acc_step.sv
// 2W-bit accumulate built from two W-bit halves with an explicit carry.
module mul_acc_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] acc_lo_i,
  input  logic [W-1:0] acc_hi_i,
  input  logic [W-1:0] mc_lo_i,
  input  logic [W-1:0] mc_hi_i,
  output logic [W-1:0] sum_lo_o,
  output logic [W-1:0] sum_hi_o
);
  logic [W:0] lo_wide;
  always_comb begin
    lo_wide  = {1'b0, acc_lo_i} + {1'b0, mc_lo_i};
    sum_lo_o = lo_wide[W-1:0];
    sum_hi_o = acc_hi_i + mc_hi_i + W'(lo_wide[W]);
  end
endmodule

// File: rtl/mul_negate.sv
// Two's-complement negation of a 2W-bit value held as two halves.
module mul_negate #(
  parameter int W = 32
) (
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  always_comb begin
    lo_o = ~lo_i + W'(1);
    hi_o = ~hi_i + W'(lo_o == '0);
  end
endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul
  import shiftadd_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         is_signed_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] prod_hi_o,
  output logic [W-1:0] prod_lo_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  mul_state_e    state_q;
  logic [W-1:0]  mc_lo_q, mc_hi_q, mplier_q;
  logic [W-1:0]  acc_lo_q, acc_hi_q;
  logic [W-1:0]  res_hi_q, res_lo_q;
  logic          neg_q, done_q;
  logic [CW-1:0] step_q;

  logic [W-1:0]  mag_a, mag_b;
  logic          neg_a, neg_b;
  logic [W-1:0]  sum_lo, sum_hi, nxt_lo, nxt_hi, inv_lo, inv_hi;
  logic          last_step;

  mul_magnitude #(.W(W)) mag_a_i (
    .val_i(opa_i), .is_signed_i(is_signed_i), .mag_o(mag_a), .neg_o(neg_a)
  );
  mul_magnitude #(.W(W)) mag_b_i (
    .val_i(opb_i), .is_signed_i(is_signed_i), .mag_o(mag_b), .neg_o(neg_b)
  );

  mul_acc_step #(.W(W)) add_i (
    .acc_lo_i(acc_lo_q), .acc_hi_i(acc_hi_q),
    .mc_lo_i(mc_lo_q),   .mc_hi_i(mc_hi_q),
    .sum_lo_o(sum_lo),   .sum_hi_o(sum_hi)
  );

  mul_negate #(.W(W)) neg_i (
    .lo_i(acc_lo_q), .hi_i(acc_hi_q), .lo_o(inv_lo), .hi_o(inv_hi)
  );

  always_comb begin
    nxt_lo    = mplier_q[0] ? sum_lo : acc_lo_q;
    nxt_hi    = mplier_q[0] ? sum_hi : acc_hi_q;
    last_step = (mplier_q[W-1:1] == '0) || (step_q == LAST_STEP);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mc_lo_q  <= '0;
      mc_hi_q  <= '0;
      mplier_q <= '0;
      acc_lo_q <= '0;
      acc_hi_q <= '0;
      res_hi_q <= '0;
      res_lo_q <= '0;
      neg_q    <= 1'b0;
      done_q   <= 1'b0;
      step_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (mag_a == '0 || mag_b == '0) begin
              res_hi_q <= '0;
              res_lo_q <= '0;
              done_q   <= 1'b1;
            end else begin
              mc_lo_q  <= mag_a;
              mc_hi_q  <= '0;
              mplier_q <= mag_b;
              acc_lo_q <= '0;
              acc_hi_q <= '0;
              neg_q    <= neg_a ^ neg_b;
              step_q   <= '0;
              state_q  <= ST_STEP;
            end
          end
        end
        ST_STEP: begin
          step_q   <= step_q + CW'(1);
          acc_lo_q <= nxt_lo;
          acc_hi_q <= nxt_hi;
          if (last_step) begin
            if (neg_q) begin
              state_q <= ST_FIX;
            end else begin
              res_hi_q <= nxt_hi;
              res_lo_q <= nxt_lo;
              done_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end
          end else begin
            mc_hi_q  <= {mc_hi_q[W-2:0], mc_lo_q[W-1]};
            mc_lo_q  <= {mc_lo_q[W-2:0], 1'b0};
            mplier_q <= {1'b0, mplier_q[W-1:1]};
          end
        end
        ST_FIX: begin
          res_hi_q <= inv_hi;
          res_lo_q <= inv_lo;
          done_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign prod_hi_o = res_hi_q;
  assign prod_lo_o = res_lo_q;
endmodule

// File: rtl/shiftadd_mul_chk.sv
module shiftadd_mul_chk #(
  parameter int W = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       start_i,
  input logic [W-1:0]               opa_i,
  input logic [W-1:0]               opb_i,
  input logic                       busy_o,
  input logic                       done_o,
  input logic [W-1:0]               prod_hi_o,
  input logic [W-1:0]               prod_lo_o,
  input logic [$clog2(W+1)-1:0]     step_q
);
  // R4
  zero_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (opa_i == '0 || opb_i == '0)) |=>
      (done_o && !busy_o && prod_hi_o == '0 && prod_lo_o == '0));

  // R5
  busy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R5
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(prod_hi_o) && $stable(prod_lo_o)));

  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  // R9
  step_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (int'(step_q) <= W));
endmodule

bind shiftadd_mul shiftadd_mul_chk #(.W(W)) chk_i (.*);

// File: tb/shiftadd_mul_tb_top.sv
`timescale 1ns/1ps
module shiftadd_mul_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc_total = 0;

  // 32-bit instance
  logic        l_start = 1'b0, l_sm = 1'b0;
  logic [31:0] l_a = '0, l_b = '0;
  logic        l_busy, l_done;
  logic [31:0] l_hi, l_lo;
  shiftadd_mul #(.W(32)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(l_start), .opa_i(l_a), .opb_i(l_b),
    .is_signed_i(l_sm), .busy_o(l_busy), .done_o(l_done),
    .prod_hi_o(l_hi), .prod_lo_o(l_lo)
  );

  // 4-bit instance for the exhaustive sweep
  logic       s_start = 1'b0, s_sm = 1'b0;
  logic [3:0] s_a = '0, s_b = '0;
  logic       s_busy, s_done;
  logic [3:0] s_hi, s_lo;
  shiftadd_mul #(.W(4)) dut_s (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s_start), .opa_i(s_a), .opb_i(s_b),
    .is_signed_i(s_sm), .busy_o(s_busy), .done_o(s_done),
    .prod_hi_o(s_hi), .prod_lo_o(s_lo)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mask_of(input int w);
    return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] sext(input logic [63:0] v, input int w, input bit sm);
    logic [63:0] m = mask_of(w);
    logic [63:0] x = v & m;
    if (sm && x[w-1]) x = x | ~m;
    return x;
  endfunction

  function automatic logic [63:0] ref_prod(input logic [63:0] a, input logic [63:0] b, input int w, input bit sm);
    return (sext(a, w, sm) * sext(b, w, sm)) & mask_of(2 * w);
  endfunction

  function automatic int ref_cycles(input logic [63:0] a, input logic [63:0] b, input int w, input bit sm);
    logic [63:0] m = mask_of(w);
    logic [63:0] ma = a & m;
    logic [63:0] mb = b & m;
    bit na = sm && ma[w-1];
    bit nb = sm && mb[w-1];
    int k = 0;
    if (ma == 0 || mb == 0) return 1;
    if (nb) mb = (~mb + 64'd1) & m;
    for (int i = 0; i < w; i++) if (mb[i]) k = i + 1;
    return k + 1 + ((na ^ nb) ? 1 : 0);
  endfunction

  task automatic run_op(input int w, input logic [63:0] a, input logic [63:0] b, input bit sm);
    int cyc;
    logic dn;
    logic [63:0] got, exp;
    int ecyc;
    string preq, lreq;
    @(negedge clk);
    if (w == 4) begin s_a = a[3:0]; s_b = b[3:0]; s_sm = sm; s_start = 1'b1; end
    else begin l_a = a[31:0]; l_b = b[31:0]; l_sm = sm; l_start = 1'b1; end
    @(negedge clk);
    s_start = 1'b0; l_start = 1'b0;
    cyc = 1;
    dn = (w == 4) ? s_done : l_done;
    while (!dn && cyc < 100) begin
      @(negedge clk);
      cyc++;
      dn = (w == 4) ? s_done : l_done;
    end
    got  = (w == 4) ? {56'd0, s_hi, s_lo} : {l_hi, l_lo};
    exp  = ref_prod(a, b, w, sm);
    ecyc = ref_cycles(a, b, w, sm);
    preq = sm ? "R3 signed product" : "R2 unsigned product";
    if (ecyc == 1) lreq = "R4 zero-operand latency";
    else if (sm && (sext(a, w, 1) ^ sext(b, w, 1)) >> 63) lreq = "R6 negative latency";
    else lreq = "R5 latency";
    chk(got == exp, preq, got, exp);
    chk(cyc == ecyc, lreq, 64'(cyc), 64'(ecyc));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc_total++;
      if (cyc_total > 190000) begin
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=%0d expected<190000 cycles", cyc_total);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] held;
    int cyc;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!l_busy && !l_done, "R1 reset flags", {62'd0, l_busy, l_done}, 64'd0);
    chk({l_hi, l_lo} == 64'd0, "R1 reset product", {l_hi, l_lo}, 64'd0);

    // Exhaustive 4-bit sweep, both modes (R2..R6)
    for (int sm = 0; sm < 2; sm++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run_op(4, 64'(a), 64'(b), sm[0]);

    // Directed 32-bit corners
    for (int sm = 0; sm < 2; sm++) begin
      run_op(32, 64'h0, 64'h1234_5678, sm[0]);
      run_op(32, 64'hdead_beef, 64'h0, sm[0]);
      run_op(32, 64'hffff_ffff, 64'hffff_ffff, sm[0]);
      run_op(32, 64'h8000_0000, 64'h8000_0000, sm[0]);
      run_op(32, 64'h8000_0000, 64'hffff_ffff, sm[0]);
      run_op(32, 64'h8000_0000, 64'h0000_0001, sm[0]);
      run_op(32, 64'h7fff_ffff, 64'h8000_0000, sm[0]);
      run_op(32, 64'h0000_0001, 64'h0000_0001, sm[0]);
      run_op(32, 64'hffff_ffff, 64'h0000_0002, sm[0]);
    end

    // R9: top multiplier bit set takes W+1 cycles
    @(negedge clk);
    l_a = 32'd3; l_b = 32'h8000_0000; l_sm = 1'b0; l_start = 1'b1;
    @(negedge clk);
    l_start = 1'b0;
    // R7: a start while busy must be dropped
    repeat (3) @(negedge clk);
    l_a = 32'd5; l_b = 32'd7; l_start = 1'b1;
    @(negedge clk);
    l_start = 1'b0;
    cyc = 5;
    while (!l_done && cyc < 100) begin @(negedge clk); cyc++; end
    chk(cyc == 33, "R9 full-length latency", 64'(cyc), 64'd33);
    chk({l_hi, l_lo} == 64'h1_8000_0000, "R7 in-flight result kept", {l_hi, l_lo}, 64'h1_8000_0000);
    held = {l_hi, l_lo};
    @(negedge clk);
    chk(!l_done, "R8 done single pulse", {63'd0, l_done}, 64'd0);
    cyc = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (l_done || l_busy) cyc++;
    end
    chk(cyc == 0, "R7 no second operation", 64'(cyc), 64'd0);
    chk({l_hi, l_lo} == held, "R8 product holds", {l_hi, l_lo}, held);

    // Random 32-bit operands, both modes
    for (int i = 0; i < 400; i++)
      run_op(32, 64'($urandom), 64'($urandom), i[0]);
    for (int i = 0; i < 100; i++)
      run_op(32, 64'($urandom), 64'($urandom & 32'h0000_00ff), i[0]);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule